// File: doc/BRIEF.md
# Edge-Timed Low-Side Current Sample Scheduler

This block decides when the low-side current of an antenna output is sampled while a data telegram is being sent. It watches the serial data-bit stream on the output, picks out the edges that qualify, and alternates between two measurement slots. The first, third, fifth and later odd qualifying edges belong to slot 1. The even ones belong to slot 2. Each slot has its own edge polarity, its own 9-bit delay code counted in internal clock ticks, and its own 3-bit output channel.

When a slot's delay runs out, the block raises a request to a shared current converter for that channel's low side. It holds the request until the converter acknowledges it, and then writes the 5-bit sample into the slot's result register. Each new sample replaces the old one, for as long as transmission continues. The converter itself lies outside the block.

Top module: `cmeas_sched`

## Requirements
- R1: Each slot qualifies edges by its own polarity select: 0 means a low-to-high change of `data_bit`, 1 means a high-to-low change. An edge of the other polarity is not counted.
- R2: Qualifying edges go to the two slots in turn. After `tx_active` rises, the first edge that matches slot 1's polarity goes to slot 1. From then on, the next edge that matches the polarity of whichever slot is due goes to that slot.
- R3: A slot armed at clock edge E issues its request one cycle after the edge that carries its code-th `tick` following E.
- R4: `adc_chan` carries the 3-bit channel of the slot being served (0 selects output 1 and 7 selects output 8), as captured when that slot was armed.
- R5: A delay code of 0 or of 511 disables its slot. No request follows, but the edge still counts for the alternation.
- R6: An edge that falls to a slot whose timer is still running, or whose sample is still waiting, is dropped. The running timer finishes at its original time.
- R7: `adc_req` stays high, and `adc_chan` stays unchanged, until a cycle in which `adc_ack` is high.
- R8: In the cycle that `adc_ack` is seen with `adc_req` high, `adc_result` is written into the served slot's result register (slot 1 to `result1`, slot 2 to `result2`) and the request drops. Result registers reset to 0 and do not change at any other time.
- R9: While `tx_active` is low, no slot is armed. A timer that is running or a sample that has not been issued is cancelled, and the alternation restarts.
- R10: When both slots are waiting for the converter, slot 1 is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable at the internal clock rate; the delays count these pulses |
| tx_active | input | 1 | High while a telegram is being transmitted |
| data_bit | input | 1 | Transmitted data-bit level |
| trig1_fall | input | 1 | Slot 1 polarity: 0 rising, 1 falling |
| trig2_fall | input | 1 | Slot 2 polarity: 0 rising, 1 falling |
| delay1_code | input | 9 | Slot 1 delay in ticks (0 and 511 disable) |
| delay2_code | input | 9 | Slot 2 delay in ticks (0 and 511 disable) |
| chan1_sel | input | 3 | Slot 1 output channel |
| chan2_sel | input | 3 | Slot 2 output channel |
| adc_ack | input | 1 | Converter acknowledge; `adc_result` is valid with it |
| adc_result | input | 5 | Converted current sample |
| adc_req | output | 1 | Conversion request, held until acknowledge |
| adc_chan | output | 3 | Channel whose low side is to be sampled |
| result1 | output | 5 | Latest slot 1 sample |
| result2 | output | 5 | Latest slot 2 sample |

## Verification
The bench builds the block with its default widths: 9-bit delay codes, 3-bit channels and 5-bit samples. The full-width code brings the two disabling values 0 and 511 within reach. Short codes between 2 and 60 ticks, with a tick every third clock, keep each run to a few hundred cycles. This makes it practical to test overlapping slots, the drop of an edge that meets a busy timer, and two slots expiring on the same tick.

// File: rtl/cmeas_pkg.sv
package cmeas_pkg;
  localparam int NUM_SLOTS = 2;
  typedef enum logic [0:0] {
    SLOT_ODD  = 1'b0,
    SLOT_EVEN = 1'b1
  } slot_e;
endpackage

// File: rtl/cmeas_edge_track.sv
module cmeas_edge_track
  import cmeas_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_active,
  input  logic                 data_bit,
  input  logic [NUM_SLOTS-1:0] fall_sel,
  output logic [NUM_SLOTS-1:0] arm_hit
);
  logic  prev_q;
  slot_e due_q;
  logic  rise_w, fall_w, qual_w;

  assign rise_w = data_bit & ~prev_q;
  assign fall_w = ~data_bit & prev_q;
  assign qual_w = tx_active & (fall_sel[due_q] ? fall_w : rise_w);

  always_comb begin
    arm_hit = '0;
    if (qual_w) arm_hit[due_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      due_q  <= SLOT_ODD;
    end else begin
      prev_q <= data_bit;
      if (!tx_active)  due_q <= SLOT_ODD;
      else if (qual_w) due_q <= (due_q == SLOT_ODD) ? SLOT_EVEN : SLOT_ODD;
    end
  end
endmodule

// File: rtl/cmeas_timer.sv
module cmeas_timer #(
  parameter int CODE_W = 9,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_active,
  input  logic              arm,
  input  logic              blocked,
  input  logic [CODE_W-1:0] code,
  input  logic [CH_W-1:0]   chan_in,
  output logic              running,
  output logic              expire,
  output logic [CH_W-1:0]   chan_q
);
  localparam logic [CODE_W-1:0] CODE_OFF_HI = '1;
  localparam logic [CODE_W-1:0] CNT_LAST    = CODE_W'(1);

  logic [CODE_W-1:0] cnt_q;
  logic              run_q;
  logic              code_ok, start;

  assign code_ok = (code != '0) && (code != CODE_OFF_HI);
  assign start   = tx_active && arm && !blocked && !run_q && code_ok;
  assign expire  = tx_active && run_q && tick && (cnt_q == CNT_LAST);
  assign running = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      chan_q <= '0;
    end else if (!tx_active) begin
      run_q <= 1'b0;
    end else if (start) begin
      run_q  <= 1'b1;
      cnt_q  <= code;
      chan_q <= chan_in;
    end else if (run_q && tick) begin
      if (cnt_q == CNT_LAST) run_q <= 1'b0;
      cnt_q <= cnt_q - CNT_LAST;
    end
  end
endmodule

// File: rtl/cmeas_adc_port.sv
module cmeas_adc_port
  import cmeas_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            tx_active,
  input  logic [NUM_SLOTS-1:0]            expire,
  input  logic [NUM_SLOTS-1:0][CH_W-1:0]  slot_chan,
  input  logic                            adc_ack,
  input  logic [RES_W-1:0]                adc_result,
  output logic                            adc_req,
  output logic [CH_W-1:0]                 adc_chan,
  output logic [NUM_SLOTS-1:0]            blocked,
  output logic [NUM_SLOTS-1:0][RES_W-1:0] result
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0]            pend_q;
  logic                            req_q;
  logic [SLOT_W-1:0]               slot_q;
  logic [CH_W-1:0]                 chan_q;
  logic [NUM_SLOTS-1:0][RES_W-1:0] res_q;
  logic                            gnt_any;
  logic [SLOT_W-1:0]               gnt_idx;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        gnt_any = 1'b1;
        gnt_idx = SLOT_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_block
    assign blocked[g] = pend_q[g] | (req_q && (slot_q == SLOT_W'(g)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      req_q  <= 1'b0;
      slot_q <= '0;
      chan_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) res_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (!tx_active)     pend_q[i] <= 1'b0;
        else if (expire[i]) pend_q[i] <= 1'b1;
      end
      if (!req_q) begin
        if (gnt_any && tx_active) begin
          req_q           <= 1'b1;
          slot_q          <= gnt_idx;
          chan_q          <= slot_chan[gnt_idx];
          pend_q[gnt_idx] <= 1'b0;
        end
      end else if (adc_ack) begin
        req_q         <= 1'b0;
        res_q[slot_q] <= adc_result;
      end
    end
  end

  assign adc_req  = req_q;
  assign adc_chan = chan_q;
  assign result   = res_q;
endmodule

// File: rtl/cmeas_sched.sv
module cmeas_sched
  import cmeas_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int CH_W   = 3,
  parameter int RES_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_active,
  input  logic              data_bit,
  input  logic              trig1_fall,
  input  logic              trig2_fall,
  input  logic [CODE_W-1:0] delay1_code,
  input  logic [CODE_W-1:0] delay2_code,
  input  logic [CH_W-1:0]   chan1_sel,
  input  logic [CH_W-1:0]   chan2_sel,
  input  logic              adc_ack,
  input  logic [RES_W-1:0]  adc_result,
  output logic              adc_req,
  output logic [CH_W-1:0]   adc_chan,
  output logic [RES_W-1:0]  result1,
  output logic [RES_W-1:0]  result2
);
  logic [NUM_SLOTS-1:0]            fall_sel;
  logic [NUM_SLOTS-1:0]            arm_hit;
  logic [NUM_SLOTS-1:0]            timer_run;
  logic [NUM_SLOTS-1:0]            expire;
  logic [NUM_SLOTS-1:0]            blocked;
  logic [NUM_SLOTS-1:0][CODE_W-1:0] code_arr;
  logic [NUM_SLOTS-1:0][CH_W-1:0]   chan_arr;
  logic [NUM_SLOTS-1:0][CH_W-1:0]   chan_held;
  logic [NUM_SLOTS-1:0][RES_W-1:0]  res_arr;

  assign fall_sel = {trig2_fall, trig1_fall};
  assign code_arr = {delay2_code, delay1_code};
  assign chan_arr = {chan2_sel, chan1_sel};

  cmeas_edge_track u_edge (
    .clk       (clk),
    .rst       (rst),
    .tx_active (tx_active),
    .data_bit  (data_bit),
    .fall_sel  (fall_sel),
    .arm_hit   (arm_hit)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    cmeas_timer #(.CODE_W(CODE_W), .CH_W(CH_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .tx_active (tx_active),
      .arm       (arm_hit[s]),
      .blocked   (blocked[s]),
      .code      (code_arr[s]),
      .chan_in   (chan_arr[s]),
      .running   (timer_run[s]),
      .expire    (expire[s]),
      .chan_q    (chan_held[s])
    );
  end

  cmeas_adc_port #(.CH_W(CH_W), .RES_W(RES_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .tx_active  (tx_active),
    .expire     (expire),
    .slot_chan  (chan_held),
    .adc_ack    (adc_ack),
    .adc_result (adc_result),
    .adc_req    (adc_req),
    .adc_chan   (adc_chan),
    .blocked    (blocked),
    .result     (res_arr)
  );

  assign result1 = res_arr[0];
  assign result2 = res_arr[1];
endmodule

// File: rtl/cmeas_sched_chk.sv
module cmeas_sched_chk #(
  parameter int CH_W  = 3,
  parameter int RES_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_active,
  input logic             adc_req,
  input logic             adc_ack,
  input logic [CH_W-1:0]  adc_chan,
  input logic [RES_W-1:0] result1,
  input logic [RES_W-1:0] result2,
  input logic [1:0]       arm_hit,
  input logic [1:0]       timer_run
);
  assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
    (adc_req && !adc_ack) |=> (adc_req && $stable(adc_chan)));

  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (adc_req && adc_ack) |=> !adc_req);

  assert_result_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(adc_req && adc_ack) |=> ($stable(result1) && $stable(result2)));

  assert_single_arm_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(arm_hit));

  assert_no_arm_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> (arm_hit == 2'b00));

  assert_timer_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    !tx_active |=> (timer_run == 2'b00));
endmodule

bind cmeas_sched cmeas_sched_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_active (tx_active),
  .adc_req   (adc_req),
  .adc_ack   (adc_ack),
  .adc_chan  (adc_chan),
  .result1   (result1),
  .result2   (result2),
  .arm_hit   (arm_hit),
  .timer_run (timer_run)
);

// File: tb/cmeas_sched_tb.sv
module cmeas_sched_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       tx_active = 1'b0;
  logic       data_bit = 1'b0;
  logic       trig1_fall = 1'b0, trig2_fall = 1'b0;
  logic [8:0] delay1_code = 9'd7, delay2_code = 9'd11;
  logic [2:0] chan1_sel = 3'd3, chan2_sel = 3'd6;
  logic       adc_ack = 1'b0;
  logic [4:0] adc_result = 5'd0;
  logic       adc_req;
  logic [2:0] adc_chan;
  logic [4:0] result1, result2;

  int checks = 0, fails = 0;
  bit finished = 0;

  cmeas_sched u_dut (
    .clk(clk), .rst(rst), .tick(tick), .tx_active(tx_active), .data_bit(data_bit),
    .trig1_fall(trig1_fall), .trig2_fall(trig2_fall),
    .delay1_code(delay1_code), .delay2_code(delay2_code),
    .chan1_sel(chan1_sel), .chan2_sel(chan2_sel),
    .adc_ack(adc_ack), .adc_result(adc_result),
    .adc_req(adc_req), .adc_chan(adc_chan), .result1(result1), .result2(result2)
  );

  always #5 clk = ~clk;

  int phase = 0;
  always @(negedge clk) begin
    if (rst) begin
      phase <= 0;
      tick  <= 1'b0;
    end else begin
      phase <= (phase == 2) ? 0 : phase + 1;
      tick  <= (phase == 1);
    end
  end

  int ticks_seen = 0;
  logic last_tick = 1'b0;
  always @(posedge clk) begin
    last_tick <= tick;
    if (rst) ticks_seen <= 0;
    else if (tick) ticks_seen <= ticks_seen + 1;
  end

  int resp_delay = 2;
  int wcnt = 0, cur_tick = 0, n_acks = 0;
  bit seen = 0;
  int log_chan[128], log_val[128], log_tick[128];
  always @(negedge clk) begin
    if (adc_ack) adc_ack = 1'b0;
    else if (adc_req && !rst) begin
      if (!seen) begin
        seen = 1;
        cur_tick = ticks_seen;
        wcnt = 0;
      end
      if (wcnt >= resp_delay) begin
        adc_result = 5'($urandom % 32);
        adc_ack = 1'b1;
        log_chan[n_acks] = int'(adc_chan);
        log_val[n_acks]  = int'(adc_result);
        log_tick[n_acks] = cur_tick;
        n_acks = n_acks + 1;
        seen = 0;
      end else wcnt = wcnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_delay(input int code);
    return (code == 0 || code == 511) ? -1 : code;
  endfunction

  task automatic set_bit(input logic v, output int t);
    @(negedge clk);
    data_bit = v;
    @(negedge clk);
    t = ticks_seen;
  endtask

  task automatic restart(input logic level);
    @(negedge clk);
    tx_active = 1'b0;
    data_bit = level;
    repeat (3) @(negedge clk);
    tx_active = 1'b1;
  endtask

  task automatic wait_acks(input int target, input string tag);
    int g = 0;
    while (n_acks < target && g < 3000) begin
      @(posedge clk);
      g++;
    end
    check(n_acks >= target, tag, n_acks, target);
    @(negedge clk);
  endtask

  task automatic check_slot(input int k, input int t_arm, input int code, input int ch,
                            input int slot, input string tag);
    check(log_chan[k] == ch, {tag, " chan R4"}, log_chan[k], ch);
    check(log_tick[k] - t_arm == exp_delay(code), {tag, " delay R3"}, log_tick[k] - t_arm, code);
    if (slot == 1) check(int'(result1) == log_val[k], {tag, " result1 R8"}, int'(result1), log_val[k]);
    else           check(int'(result2) == log_val[k], {tag, " result2 R8"}, int'(result2), log_val[k]);
  endtask

  initial begin
    int ta, tb, tx, n0, lvl;
    void'($urandom(32'h1F3A));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(adc_req == 1'b0, "reset req R7", int'(adc_req), 0);
    check(result1 == 5'd0 && result2 == 5'd0, "reset results R8", int'(result1) + int'(result2), 0);

    // R1 R2: both rising; falling edge between them is skipped
    restart(1'b0);
    n0 = n_acks;
    set_bit(1'b1, ta);
    set_bit(1'b0, tx);
    set_bit(1'b1, tb);
    wait_acks(n0 + 2, "alternation R2");
    check_slot(n0, ta, 7, 3, 1, "rise slot1 R1");
    check_slot(n0 + 1, tb, 11, 6, 2, "rise slot2 R2");

    // R1: falling select ignores a rising edge
    trig1_fall = 1'b1; trig2_fall = 1'b1;
    restart(1'b0);
    n0 = n_acks;
    set_bit(1'b1, tx);
    repeat (150) @(negedge clk);
    check(n_acks == n0, "rising ignored R1", n_acks, n0);
    set_bit(1'b0, ta);
    wait_acks(n0 + 1, "falling slot1 R1");
    check_slot(n0, ta, 7, 3, 1, "fall slot1 R1");

    // mixed polarity, overlapping slots
    trig1_fall = 1'b0; trig2_fall = 1'b1;
    restart(1'b0);
    n0 = n_acks;
    set_bit(1'b1, ta);
    set_bit(1'b0, tb);
    wait_acks(n0 + 2, "mixed R2");
    check_slot(n0, ta, 7, 3, 1, "mixed slot1 R2");
    check_slot(n0 + 1, tb, 11, 6, 2, "mixed slot2 R2");

    // R5: disabled codes still consume an edge
    trig1_fall = 1'b0; trig2_fall = 1'b0;
    for (int c = 0; c < 2; c++) begin
      int keep;
      keep = int'(result1);
      delay1_code = (c == 0) ? 9'd0 : 9'd511;
      restart(1'b0);
      n0 = n_acks;
      set_bit(1'b1, tx);
      set_bit(1'b0, tx);
      set_bit(1'b1, tb);
      wait_acks(n0 + 1, "disabled R5");
      repeat (200) @(negedge clk);
      check(n_acks == n0 + 1, "disabled no request R5", n_acks, n0 + 1);
      check(log_chan[n0] == 6, "disabled skip slot R5", log_chan[n0], 6);
      check(int'(result1) == keep, "disabled result1 kept R5", int'(result1), keep);
    end

    // R6: edge meeting a running timer is dropped
    delay1_code = 9'd60; delay2_code = 9'd5;
    trig1_fall = 1'b0; trig2_fall = 1'b1;
    restart(1'b0);
    n0 = n_acks;
    set_bit(1'b1, ta);
    set_bit(1'b0, tx);
    wait_acks(n0 + 1, "drop first slot2 R6");
    set_bit(1'b1, tx);
    set_bit(1'b0, tx);
    wait_acks(n0 + 3, "drop sequence R6");
    repeat (200) @(negedge clk);
    check(n_acks == n0 + 3, "drop count R6", n_acks, n0 + 3);
    check(log_chan[n0 + 2] == 3, "drop slot1 last R6", log_chan[n0 + 2], 3);
    check(log_tick[n0 + 2] - ta == 60, "drop timer unchanged R6", log_tick[n0 + 2] - ta, 60);

    // R10: both slots expire on the same tick
    delay1_code = 9'd9; delay2_code = 9'd9;
    resp_delay = 3;
    restart(1'b0);
    n0 = n_acks;
    @(negedge clk);
    while (!last_tick) @(negedge clk);
    data_bit = 1'b1;
    @(negedge clk);
    data_bit = 1'b0;
    wait_acks(n0 + 2, "priority R10");
    check(log_chan[n0] == 3, "priority first R10", log_chan[n0], 3);
    check(log_chan[n0 + 1] == 6, "priority second R10", log_chan[n0 + 1], 6);

    // R7: request held while the converter is slow
    delay1_code = 9'd4;
    resp_delay = 8;
    restart(1'b0);
    n0 = n_acks;
    set_bit(1'b1, tx);
    while (!adc_req) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(adc_req == 1'b1 && adc_chan == 3'd3, "req held R7", int'(adc_chan), 3);
    end
    wait_acks(n0 + 1, "slow ack R7");
    resp_delay = 2;

    // R9: idle edges ignored, running timer cancelled, alternation restarts
    n0 = n_acks;
    @(negedge clk);
    tx_active = 1'b0;
    set_bit(1'b1, tx);
    set_bit(1'b0, tx);
    set_bit(1'b1, tx);
    repeat (200) @(negedge clk);
    check(n_acks == n0, "idle edges R9", n_acks, n0);
    delay1_code = 9'd30; trig2_fall = 1'b0;
    restart(1'b0);
    set_bit(1'b1, tx);
    repeat (20) @(negedge clk);
    tx_active = 1'b0;
    repeat (150) @(negedge clk);
    check(n_acks == n0, "cancel R9", n_acks, n0);
    delay1_code = 9'd5; delay2_code = 9'd8;
    restart(1'b0);
    set_bit(1'b1, ta);
    wait_acks(n0 + 1, "restart R9");
    check(log_chan[n0] == 3, "restart slot1 first R9", log_chan[n0], 3);

    // constrained random trials
    for (int r = 0; r < 8; r++) begin
      int c1, c2, h1, h2;
      c1 = 2 + int'($urandom % 39);
      c2 = 2 + int'($urandom % 39);
      h1 = int'($urandom % 8);
      h2 = (h1 + 1 + int'($urandom % 7)) % 8;
      delay1_code = 9'(c1); delay2_code = 9'(c2);
      chan1_sel = 3'(h1); chan2_sel = 3'(h2);
      trig1_fall = 1'($urandom % 2); trig2_fall = 1'($urandom % 2);
      resp_delay = int'($urandom % 5);
      lvl = trig1_fall ? 1 : 0;
      restart(1'(lvl));
      n0 = n_acks;
      set_bit(1'(1 - lvl), ta);
      wait_acks(n0 + 1, "random slot1 R3");
      check_slot(n0, ta, c1, h1, 1, "random slot1 R1");
      lvl = 1 - lvl;
      if ((lvl == 0) == (trig2_fall == 1'b0)) set_bit(1'(1 - lvl), tb);
      else begin
        set_bit(1'(1 - lvl), tx);
        set_bit(1'(lvl), tb);
      end
      wait_acks(n0 + 2, "random slot2 R3");
      check_slot(n0 + 1, tb, c2, h2, 2, "random slot2 R2");
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule